// File: doc/BRIEF.md
# ALU Select Decoder

This block produces the 4-bit select code that steers the arithmetic unit of a 32-bit single-issue processor. The main instruction decoder does not resolve every arithmetic operation. It reduces each instruction to a coarse 2-bit class. Memory accesses use that class to get an address addition, and the equality branch uses it to get a comparison subtraction. For register-to-register arithmetic, the class hands the choice to this block, which then reads the instruction's 6-bit function field.

The block is purely combinational and holds no state. The R-format lookup uses only the low four bits of the function field. A function code that matches no supported operation produces a reserved code. That code selects no real operation, so an invalid instruction can never quietly turn into a valid one.

Top module: `alu_dec`

## Requirements
- R1: With `alu_op_i` = 2'b00 (memory class), `alu_ctrl_o` is 4'b0010 (add) for every `funct_i` value.
- R2: Whenever `alu_op_i[0]` is 1 (2'b01 branch class, and also 2'b11), `alu_ctrl_o` is 4'b0110 (subtract) for every `funct_i` value. Bit 0 takes priority over bit 1.
- R3: With `alu_op_i` = 2'b10 (R-format class), a low function nibble `funct_i[3:0]` of 4'b0000 gives 4'b0010 (add), and 4'b0010 gives 4'b0110 (subtract).
- R4: With `alu_op_i` = 2'b10, a low nibble of 4'b0100 gives 4'b0000 (AND), and 4'b0101 gives 4'b0001 (OR).
- R5: With `alu_op_i` = 2'b10, a low nibble of 4'b1010 gives 4'b0111 (set-on-less-than).
- R6: In the R-format class, `funct_i[5:4]` has no effect. All four values of these bits give the same output for a given low nibble.
- R7: In the R-format class, any low nibble not listed in R3 to R5 gives 4'b1111. This code differs from each of 0000, 0001, 0010, 0110 and 0111.
- R8: The output depends only on the present inputs. It settles within the same time step as an input change, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_op_i | input | 2 | Coarse operation class from the main decoder |
| funct_i | input | 6 | Function field of the current instruction |
| alu_ctrl_o | output | 4 | Select code for the arithmetic unit |

## Verification
The bench builds the block with its package defaults: a 2-bit class, a 6-bit function field, a 4-bit lookup key and a 4-bit select code. With these widths the whole input space is only 256 combinations, so the bench applies every class with every function value. It compares each output against a table it computes from the requirements. Because the sweep is complete, it covers the bit-0 priority for class 11, every don't-care pattern in the two upper function bits, and every unsupported nibble.

// File: rtl/alu_dec_pkg.sv
package alu_dec_pkg;

    localparam int OP_W    = 2;
    localparam int FUNCT_W = 6;
    localparam int KEY_W   = 4;
    localparam int CTRL_W  = 4;
    localparam int N_OPS   = 5;

    typedef enum logic [1:0] {
        CLS_MEM    = 2'd0,
        CLS_BRANCH = 2'd1,
        CLS_RFMT   = 2'd2
    } op_class_e;

    localparam logic [CTRL_W-1:0] CTRL_AND = 4'b0000;
    localparam logic [CTRL_W-1:0] CTRL_OR  = 4'b0001;
    localparam logic [CTRL_W-1:0] CTRL_ADD = 4'b0010;
    localparam logic [CTRL_W-1:0] CTRL_SUB = 4'b0110;
    localparam logic [CTRL_W-1:0] CTRL_SLT = 4'b0111;
    localparam logic [CTRL_W-1:0] CTRL_BAD = 4'b1111;

    // entry 0 is the rightmost element
    localparam logic [N_OPS-1:0][KEY_W-1:0] KEY_TAB = {
        4'b1010, 4'b0101, 4'b0100, 4'b0010, 4'b0000
    };
    localparam logic [N_OPS-1:0][CTRL_W-1:0] CODE_TAB = {
        CTRL_SLT, CTRL_OR, CTRL_AND, CTRL_SUB, CTRL_ADD
    };

    typedef struct packed {
        logic [CTRL_W-1:0] code;
        logic              hit;
    } lut_res_t;

endpackage

// File: rtl/alu_class_dec.sv
module alu_class_dec
    import alu_dec_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output op_class_e       cls_o
);
    op_class_e cls_d;

    always_comb begin
        if (op_i[0]) begin
            cls_d = CLS_BRANCH;
        end else if (op_i[1]) begin
            cls_d = CLS_RFMT;
        end else begin
            cls_d = CLS_MEM;
        end
    end

    assign cls_o = cls_d;
endmodule

// File: rtl/alu_funct_lut.sv
module alu_funct_lut
    import alu_dec_pkg::*;
(
    input  logic [KEY_W-1:0] key_i,
    output lut_res_t         res_o
);
    logic [N_OPS-1:0] hit_vec;
    lut_res_t         res_d;

    for (genvar g = 0; g < N_OPS; g++) begin : g_entry
        assign hit_vec[g] = (key_i == KEY_TAB[g]);
    end

    always_comb begin
        res_d.code = '0;
        res_d.hit  = |hit_vec;
        for (int i = 0; i < N_OPS; i++) begin
            if (hit_vec[i]) begin
                res_d.code = res_d.code | CODE_TAB[i];
            end
        end
        if (!res_d.hit) begin
            res_d.code = CTRL_BAD;
        end
    end

    assign res_o = res_d;
endmodule

// File: rtl/alu_dec.sv
module alu_dec
    import alu_dec_pkg::*;
(
    input  logic [1:0] alu_op_i,
    input  logic [5:0] funct_i,
    output logic [3:0] alu_ctrl_o
);
    op_class_e         cls;
    lut_res_t          lut_res;
    logic [CTRL_W-1:0] ctrl_d;
    logic              unused_funct_hi;

    assign unused_funct_hi = ^funct_i[FUNCT_W-1:KEY_W];

    alu_class_dec u_class (
        .op_i  (alu_op_i),
        .cls_o (cls)
    );

    alu_funct_lut u_lut (
        .key_i (funct_i[KEY_W-1:0]),
        .res_o (lut_res)
    );

    always_comb begin
        unique case (cls)
            CLS_MEM:    ctrl_d = CTRL_ADD;
            CLS_BRANCH: ctrl_d = CTRL_SUB;
            CLS_RFMT:   ctrl_d = lut_res.code;
            default:    ctrl_d = CTRL_BAD;
        endcase
    end

    assign alu_ctrl_o = ctrl_d;
endmodule

// File: rtl/alu_dec_chk.sv
module alu_dec_chk (
    input logic [1:0] alu_op_i,
    input logic [5:0] funct_i,
    input logic [3:0] alu_ctrl_o
);
    always_comb begin
        if (!$isunknown({alu_op_i, funct_i})) begin
            AST_NO_UNKNOWN_OUT: assert (!$isunknown(alu_ctrl_o)); // R8
            if (alu_op_i == 2'b00) begin
                AST_MEM_ADD: assert (alu_ctrl_o == 4'b0010); // R1
            end
            if (alu_op_i[0]) begin
                AST_BRANCH_SUB: assert (alu_ctrl_o == 4'b0110); // R2
            end
            if (alu_op_i == 2'b10 && funct_i[3:0] == 4'b0000) begin
                AST_RFMT_ADD: assert (alu_ctrl_o == 4'b0010); // R3
            end
            if (alu_op_i == 2'b10 && funct_i[3:0] == 4'b0010) begin
                AST_RFMT_SUB: assert (alu_ctrl_o == 4'b0110); // R3
            end
            if (alu_op_i == 2'b10 && funct_i[3:0] == 4'b0100) begin
                AST_RFMT_AND: assert (alu_ctrl_o == 4'b0000); // R4
            end
            if (alu_op_i == 2'b10 && funct_i[3:0] == 4'b0101) begin
                AST_RFMT_OR: assert (alu_ctrl_o == 4'b0001); // R4
            end
            if (alu_op_i == 2'b10 && funct_i[3:0] == 4'b1010) begin
                AST_RFMT_SLT: assert (alu_ctrl_o == 4'b0111); // R5
            end
            if (alu_op_i == 2'b10 && funct_i[3:0] != 4'b0000 && funct_i[3:0] != 4'b0010 &&
                funct_i[3:0] != 4'b0100 && funct_i[3:0] != 4'b0101 && funct_i[3:0] != 4'b1010) begin
                AST_RFMT_SAFE: assert (alu_ctrl_o == 4'b1111); // R7
            end
        end
    end
endmodule

bind alu_dec alu_dec_chk u_chk (
    .alu_op_i   (alu_op_i),
    .funct_i    (funct_i),
    .alu_ctrl_o (alu_ctrl_o)
);

// File: tb/alu_dec_tb.sv
module alu_dec_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] op  = 2'b00;
    logic [5:0] fn  = 6'd0;
    logic [3:0] ctrl;
    int         n_tests = 0;
    int         n_fail  = 0;
    int         cycles  = 0;
    logic [3:0] rfmt_ref [0:15];

    alu_dec u_dut (
        .alu_op_i   (op),
        .funct_i    (fn),
        .alu_ctrl_o (ctrl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [3:0] expect_code(input logic [1:0] o, input logic [5:0] f);
        if (o[0])            return 4'b0110;  // R2
        else if (o == 2'b00) return 4'b0010;  // R1
        case (f[3:0])                           // R6: f[5:4] not used
            4'b0000: return 4'b0010;          // R3
            4'b0010: return 4'b0110;          // R3
            4'b0100: return 4'b0000;          // R4
            4'b0101: return 4'b0001;          // R4
            4'b1010: return 4'b0111;          // R5
            default: return 4'b1111;          // R7
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] o, input logic [5:0] f);
        if (o[0])            return "R2";
        else if (o == 2'b00) return "R1";
        case (f[3:0])
            4'b0000, 4'b0010: return "R3";
            4'b0100, 4'b0101: return "R4";
            4'b1010:          return "R5";
            default:          return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_tests = n_tests + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: op=%b funct=%b actual %b expected %b", req, op, fn, act, exp);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: idle inputs give the add code
        check("R1", ctrl, 4'b0010);

        // full sweep; R8: output read one step after drive, no clock edge between
        for (int o = 0; o < 4; o++) begin
            for (int f = 0; f < 64; f++) begin
                @(negedge clk);
                op = o[1:0];
                fn = f[5:0];
                #1;
                check(req_of(op, fn), ctrl, expect_code(op, fn));
                if (op == 2'b10 && f < 16) rfmt_ref[f] = ctrl;
            end
        end

        // R6: upper function bits have no effect in the R-format class
        for (int f = 0; f < 64; f++) begin
            @(negedge clk);
            op = 2'b10;
            fn = f[5:0];
            #1;
            check("R6", ctrl, rfmt_ref[f % 16]);
        end

        // R7: unsupported nibbles give a code that is not any real operation
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            op = 2'b10;
            fn = {2'b11, k[3:0]};
            #1;
            if (expect_code(op, fn) == 4'b1111) begin
                n_tests = n_tests + 1;
                if (ctrl == 4'b0000 || ctrl == 4'b0001 || ctrl == 4'b0010 ||
                    ctrl == 4'b0110 || ctrl == 4'b0111) begin
                    n_fail = n_fail + 1;
                    $display("FAIL R7: funct=%b actual %b expected 1111", fn, ctrl);
                end
            end
        end

        // R8: back-to-back changes within one clock period
        @(negedge clk);
        op = 2'b10; fn = 6'b001010; #1;
        check("R8", ctrl, 4'b0111);
        op = 2'b11; #1;
        check("R8", ctrl, 4'b0110);
        op = 2'b00; #1;
        check("R8", ctrl, 4'b0010);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule